// File: doc/BRIEF.md
# GPIO port with interrupt detection

A 32-pin general-purpose I/O port with a single-cycle register port. Software sets a per-pin output level and a per-pin drive enable. Every pin input passes through a two-stage synchronizer. The synchronized value can be read back, and it feeds a per-pin detector for a level or an edge condition.

Each detected condition sets a sticky bit in a status word. Software clears a status bit by writing 1 to it. An enable word selects which status bits reach the single interrupt line. The trigger for each pin is a 2-bit code. The codes for the low sixteen pins sit in one register and the codes for the high sixteen pins in another. A separate per-pin bit switches a pin to detect both edges, whatever its code says.

Registers are selected by a word index on `req_idx`, where byte offset = 4 × index. A request is taken on the clock edge where `req` is high. A write updates its register at that edge. A read returns its data on `rsp_rdata` one cycle later, and `rsp_rdata` holds that value until the next read.

Top module: `gpio_irq_port`

## Requirements
- R1: The output-level register (index 0, offset 0x00) and the drive-enable register (index 1, offset 0x04) read back what was written. `pad_out` equals the output-level register and `pad_oe` equals the drive-enable register. A drive-enable bit of 1 makes that pin an output.
- R2: The output-level register keeps its value while a pin is an input. When the pin is later made an output, it drives the level that was preset.
- R3: The pad register (index 2, offset 0x08) is read-only and writes to it are ignored. A read returns every pin's input after two synchronizer stages, whatever the pin's direction. A read accepted at edge E returns `pad_in` as sampled at edge E-2.
- R4: Pin n's 2-bit trigger code sits at bits [2(n mod 16)+1 : 2(n mod 16)]. Pins 0–15 use index 3 (offset 0x0C) and pins 16–31 use index 4 (offset 0x10). The codes are 00 = input low, 01 = input high, 10 = rising edge and 11 = falling edge. The codes reset to 00, so after reset every pin whose input is low sets its status bit.
- R5: When bit n of the both-edges register (index 7, offset 0x1C) is 1, pin n detects both rising and falling edges and its trigger code is ignored.
- R6: A detected condition sets bit n of the status register (index 6, offset 0x18). The bit stays set until software writes 1 to it, and writing 0 has no effect. A detection in the same cycle as the clearing write leaves the bit set, so a level condition that is still present keeps the bit set.
- R7: The enable register (index 5, offset 0x14) resets to 0. The `irq` output is the OR over all pins of status AND enable, registered, so it follows the status and enable bits one cycle later.
- R8: Reset is synchronous and active high. Reset clears all registers, `pad_out`, `pad_oe`, `irq` and `rsp_rdata`. `rsp_rdata` changes only on the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Register access request, taken at the clock edge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_idx | input | 3 | Register word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read request |
| pad_in | input | 32 | Asynchronous pin inputs |
| pad_out | output | 32 | Pin output levels |
| pad_oe | output | 32 | Pin drive enables (1 = output) |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can meet in one cycle: a clearing write to the status register and a fresh detection on the same pin. The bench provokes this with a rising edge on a pin that is set to detect rising edges. It drives the pad at a falling clock edge, waits two rising edges for the synchronizer, and then places the clearing write on exactly the edge where the detector fires. A read that follows must show the bit still set. A second clearing write, with no edge present, must then clear it. The same rule is judged with level triggers: after clear-all writes, the bench expects exactly the pins whose level condition is still true to read back as set.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    SEL_DOUT = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_PADS = 3'd2,
    SEL_CLO  = 3'd3,
    SEL_CHI  = 3'd4,
    SEL_MASK = 3'd5,
    SEL_STAT = 3'd6,
    SEL_BOTH = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] cur,
  input  logic [NPINS-1:0] cfg_lo,
  input  logic [NPINS-1:0] cfg_hi,
  input  logic [NPINS-1:0] both,
  output logic [NPINS-1:0] hit
);
  localparam int unsigned HALF = NPINS / 2;

  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] code;
    logic       h;

    if (p < HALF) begin : g_lo
      assign code = cfg_lo[2*p +: 2];
    end else begin : g_hi
      assign code = cfg_hi[2*(p-HALF) +: 2];
    end

    always_comb begin
      if (both[p]) begin
        h = cur[p] ^ prev_q[p];
      end else begin
        case (trig_e'(code))
          TRIG_LOW:  h = ~cur[p];
          TRIG_HIGH: h = cur[p];
          TRIG_RISE: h = cur[p] & ~prev_q[p];
          TRIG_FALL: h = ~cur[p] & prev_q[p];
        endcase
      end
    end

    assign hit[p] = h;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [NPINS-1:0] req_wdata,
  input  logic [NPINS-1:0] pads,
  input  logic [NPINS-1:0] hit,
  output logic [NPINS-1:0] dout,
  output logic [NPINS-1:0] dir,
  output logic [NPINS-1:0] cond_lo,
  output logic [NPINS-1:0] cond_hi,
  output logic [NPINS-1:0] both,
  output logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] stat,
  output logic [NPINS-1:0] rdata,
  output logic             irq
);
  reg_sel_e         sel;
  logic             wr_en, rd_en;
  logic [NPINS-1:0] clr;
  logic [NPINS-1:0] dout_q, dir_q, clo_q, chi_q, both_q, mask_q, stat_q;
  logic [NPINS-1:0] rd_mux;
  logic [NPINS-1:0] rdata_q;
  logic             irq_q;

  assign sel   = reg_sel_e'(req_idx);
  assign wr_en = req & req_wr;
  assign rd_en = req & ~req_wr;
  assign clr   = (wr_en && sel == SEL_STAT) ? req_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      clo_q  <= '0;
      chi_q  <= '0;
      both_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DOUT: dout_q <= req_wdata;
        SEL_DIR:  dir_q  <= req_wdata;
        SEL_CLO:  clo_q  <= req_wdata;
        SEL_CHI:  chi_q  <= req_wdata;
        SEL_MASK: mask_q <= req_wdata;
        SEL_BOTH: both_q <= req_wdata;
        default:  ;
      endcase
    end
  end

  // sticky status: a detection outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & mask_q);
  end

  always_comb begin
    case (sel)
      SEL_DOUT: rd_mux = dout_q;
      SEL_DIR:  rd_mux = dir_q;
      SEL_PADS: rd_mux = pads;
      SEL_CLO:  rd_mux = clo_q;
      SEL_CHI:  rd_mux = chi_q;
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = stat_q;
      SEL_BOTH: rd_mux = both_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign dout    = dout_q;
  assign dir     = dir_q;
  assign cond_lo = clo_q;
  assign cond_hi = chi_q;
  assign both    = both_q;
  assign mask    = mask_q;
  assign stat    = stat_q;
  assign rdata   = rdata_q;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS     = REG_W,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [NPINS-1:0] req_wdata,
  output logic [NPINS-1:0] rsp_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  logic [NPINS-1:0] pads_s, hit_w;
  logic [NPINS-1:0] clo_w, chi_w, both_w, mask_w, stat_w;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STGS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pads_s)
  );

  gpio_detect #(.NPINS(NPINS)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .cur    (pads_s),
    .cfg_lo (clo_w),
    .cfg_hi (chi_w),
    .both   (both_w),
    .hit    (hit_w)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_wr    (req_wr),
    .req_idx   (req_idx),
    .req_wdata (req_wdata),
    .pads      (pads_s),
    .hit       (hit_w),
    .dout      (pad_out),
    .dir       (pad_oe),
    .cond_lo   (clo_w),
    .cond_hi   (chi_w),
    .both      (both_w),
    .mask      (mask_w),
    .stat      (stat_w),
    .rdata     (rsp_rdata),
    .irq       (irq)
  );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = REG_W
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic             req_wr,
  input logic [IDX_W-1:0] req_idx,
  input logic [NPINS-1:0] req_wdata,
  input logic [NPINS-1:0] rsp_rdata,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic [NPINS-1:0] stat,
  input logic [NPINS-1:0] mask
);
  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                 warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  // R1
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (req && req_wr && req_idx == SEL_DIR) |=> (pad_oe == $past(req_wdata)));

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req && req_wr && req_idx == SEL_DOUT) |=> $stable(pad_out));

  // R3
  pads_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm && req && !req_wr && req_idx == SEL_PADS) |=> (rsp_rdata == $past(pad_in, 3)));

  // R6
  stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(req && req_wr && req_idx == SEL_STAT) |=> ((stat & $past(stat)) == $past(stat)));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req && !req_wr) |=> $stable(rsp_rdata));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .req_wr    (req_wr),
  .req_idx   (req_idx),
  .req_wdata (req_wdata),
  .rsp_rdata (rsp_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .stat      (stat_w),
  .mask      (mask_w)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
  localparam int NV = 31;
  localparam int WDOG_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_idx(req_idx),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {pad, write, byte offset, data or expected read}
  localparam logic [72:0] VEC [NV] = '{
    {32'h0000_0000, 1'b1, 8'h00, 32'hA5A5_0F0F},
    {32'h0000_0000, 1'b0, 8'h00, 32'hA5A5_0F0F},  // R1
    {32'h0000_0000, 1'b1, 8'h04, 32'h0000_FFFF},
    {32'h0000_0000, 1'b0, 8'h04, 32'h0000_FFFF},  // R1
    {32'h1234_5678, 1'b0, 8'h08, 32'h1234_5678},  // R3
    {32'h1234_5678, 1'b1, 8'h08, 32'hFFFF_FFFF},
    {32'h1234_5678, 1'b0, 8'h08, 32'h1234_5678},  // R3 write ignored
    {32'h0000_0000, 1'b1, 8'h0C, 32'h5555_551E},
    {32'h0000_0000, 1'b1, 8'h10, 32'hD555_5556},
    {32'h0000_0000, 1'b1, 8'h18, 32'hFFFF_FFFF},
    {32'h0000_0000, 1'b0, 8'h18, 32'h0000_0008},  // R6 low level stays
    {32'h0000_0001, 1'b0, 8'h18, 32'h0000_0009},  // R4 rise
    {32'h0000_0000, 1'b0, 8'h18, 32'h0000_0009},  // R4 fall ignored in rise mode
    {32'h0000_0002, 1'b0, 8'h18, 32'h0000_0009},  // R4 rise ignored in fall mode
    {32'h0000_0000, 1'b0, 8'h18, 32'h0000_000B},  // R4 fall
    {32'h0001_0004, 1'b0, 8'h18, 32'h0001_000F},  // R4 high, upper rise
    {32'h8001_0004, 1'b0, 8'h18, 32'h0001_000F},  // R4 upper fall mode
    {32'h0001_0004, 1'b0, 8'h18, 32'h8001_000F},  // R4 pin31 fall
    {32'h0001_0004, 1'b1, 8'h18, 32'hFFFF_FFFF},
    {32'h0001_0004, 1'b0, 8'h18, 32'h0000_000C},  // R6
    {32'h0001_0004, 1'b1, 8'h1C, 32'h0000_0001},
    {32'h0001_0005, 1'b0, 8'h18, 32'h0000_000D},  // R5 rise
    {32'h0001_0005, 1'b1, 8'h18, 32'h0000_0001},
    {32'h0001_0005, 1'b0, 8'h18, 32'h0000_000C},  // R6 single clear
    {32'h0001_0004, 1'b0, 8'h18, 32'h0000_000D},  // R5 fall overrides code
    {32'h0001_0004, 1'b1, 8'h18, 32'h0000_0000},
    {32'h0001_0004, 1'b0, 8'h18, 32'h0000_000D},  // R6 write 0 no effect
    {32'h0001_0004, 1'b0, 8'h0C, 32'h5555_551E},  // R4
    {32'h0001_0004, 1'b0, 8'h10, 32'hD555_5556},  // R4
    {32'h0001_0004, 1'b0, 8'h1C, 32'h0000_0001},  // R5
    {32'h0001_0004, 1'b0, 8'h14, 32'h0000_0000}   // R7
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_idx = off[4:2]; req_wdata = d;
    @(negedge clk);
    req = 1'b0; req_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_idx = off[4:2];
    @(negedge clk);
    req = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(WDOG_CYC * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    check("R8 pad_out", pad_out, 32'h0);
    check("R8 pad_oe", pad_oe, 32'h0);
    check("R8 irq", {31'h0, irq}, 32'h0);
    bus_read(8'h14, rd); check("R7 mask reset", rd, 32'h0);
    bus_read(8'h04, rd); check("R8 dir reset", rd, 32'h0);
    idle(2);
    bus_read(8'h18, rd); check("R4 low-level default", rd, 32'hFFFF_FFFF);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pad_in = VEC[i][72:41];
      idle(4);
      if (VEC[i][40]) begin
        bus_write(VEC[i][39:32], VEC[i][31:0]);
      end else begin
        bus_read(VEC[i][39:32], rd);
        check($sformatf("vector %0d R1..R7", i), rd, VEC[i][31:0]);
      end
    end

    // R7 interrupt combining
    check("R7 masked", {31'h0, irq}, 32'h0);
    bus_write(8'h14, 32'h0000_0004);
    idle(2);
    check("R7 pin2 enabled", {31'h0, irq}, 32'h1);
    @(negedge clk); pad_in = 32'h0001_0000;
    idle(4);
    bus_write(8'h18, 32'h0000_0004);
    idle(3);
    check("R7 irq drops", {31'h0, irq}, 32'h0);
    bus_write(8'h14, 32'h0000_0008);
    idle(2);
    check("R7 pin3 enabled", {31'h0, irq}, 32'h1);
    bus_write(8'h14, 32'h0000_0000);
    idle(2);
    check("R7 all masked", {31'h0, irq}, 32'h0);

    // R2 preset level survives direction change
    bus_write(8'h00, 32'hFFFF_0000);
    idle(1);
    check("R2 preset out", pad_out, 32'hFFFF_0000);
    check("R1 oe", pad_oe, 32'h0000_FFFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    idle(1);
    check("R2 out kept", pad_out, 32'hFFFF_0000);
    check("R1 oe all", pad_oe, 32'hFFFF_FFFF);
    bus_read(8'h00, rd); check("R2 readback", rd, 32'hFFFF_0000);

    // R6 clear colliding with a detection
    @(negedge clk); pad_in = 32'h0;
    idle(4);
    bus_write(8'h18, 32'h0001_0000);
    bus_read(8'h18, rd); check("R6 cleared", rd & 32'h0001_0000, 32'h0);
    @(negedge clk); pad_in = 32'h0001_0000;
    @(posedge clk); @(posedge clk);
    bus_write(8'h18, 32'h0001_0000);
    bus_read(8'h18, rd); check("R6 set beats clear", rd & 32'h0001_0000, 32'h0001_0000);
    bus_write(8'h18, 32'h0001_0000);
    bus_read(8'h18, rd); check("R6 later clear", rd & 32'h0001_0000, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule